// File: doc/BRIEF.md
# Set/Clear/Toggle Register Bank

This block holds the control and interrupt registers of a serial port behind a simple synchronous bus. The bus has a byte address, a write strobe, write data and combinational read data. Six control registers sit on a 16-byte stride. Each register has a plain write address and three write-only aliases. The aliases OR in, AND out or XOR in only the bits written as 1, so software can change one field without first reading the register. A read of any alias returns the register's current value.

The interrupt register pairs four enable bits with four sticky status bits. The status bits are set by single-cycle hardware event pulses and are acknowledged through the clear alias. A single interrupt output is raised whenever an enabled status bit is set. Bit 31 of the first control register is a soft reset and bit 30 is a clock gate. While the soft-reset bit is set, every register is forced to its reset value, except the soft-reset bit itself.

A three-state machine follows those two bits and drives the core reset and core clock-enable outputs one cycle after the register changes. Its states are:
- HELD: core held in reset.
- GATED: reset released, clock still gated.
- RUN: clock enabled.

Its transitions are:
- Any state goes to HELD when the soft-reset bit is 1.
- HELD goes to GATED when soft reset is 0 and the clock gate is 1.
- HELD goes to RUN when both bits are 0.
- GATED goes to RUN when the clock gate clears.
- RUN goes to GATED when the clock gate sets.

Top module: `scr_regbank`

## Requirements
- R1: Register k (k = 0..5) has its base address at k*0x10. A write to the base address stores the whole word. A read of the base address, base+4, base+8 or base+0xC returns the stored value.
- R2: A write to base+4 ORs the write data into the register. Bits written as 0 are unchanged.
- R3: A write to base+8 clears the bits written as 1. Other bits are unchanged.
- R4: A write to base+0xC inverts the bits written as 1. Other bits are unchanged.
- R5: Register 5 (0x50) is the interrupt register.
  - Its implemented bits are the enables at 17, 20, 21 and 22 and the status bits at 1, 4, 5 and 6. All other bits read 0.
  - The enable bits pair with the status bits in that order.
  - irq_o is 1 exactly when some status bit and its paired enable bit are both 1.
- R6: A pulse on evt_i[0], [1], [2] or [3] sets status bit 1, 4, 5 or 6 at the next clock edge. If software clears the same status bit in the same cycle, the bit ends up set.
- R7: Soft reset works as follows.
  - While bit 31 of register 0 is 1, every register loads its reset value at each edge. This includes the interrupt register and overrides event pulses.
  - Bit 31 itself still follows software writes during this time.
  - Clearing bit 31 is visible on the next read.
- R8: The core outputs follow the soft-reset and clock-gate bits.
  - core_rst_o is 1 only in HELD, and core_clk_en_o is 1 only in RUN.
  - Both outputs change one clock after the register 0 bits that drive them.
- R9: The addresses outside the six registers behave as follows.
  - 0x90 reads the VERSION_VAL parameter.
  - 0x60, 0x70, 0x80, 0xA0, any address with a nonzero low two bits, and every other unmapped address read 0.
  - Writes to those addresses change no register.
- R10: rst_n low loads the reset values and puts the state machine in HELD. Register 0 resets to 0xC000_0000 and all other registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| evt_i | input | 4 | Event pulses: 0 CTS change, 1 receive, 2 transmit, 3 receive timeout |
| irq_o | output | 1 | Interrupt request |
| core_rst_o | output | 1 | Core reset (state HELD) |
| core_clk_en_o | output | 1 | Core clock enable (state RUN) |

## Verification
Two functions can meet in the same cycle: a hardware event setting a status bit, and a software write to the clear alias of the interrupt register. The bench drives an event pulse and a clear-alias write with the same bit on the same clock edge, then reads the register back and expects the bit to be set. In a second case, the clear targets one status bit while the event sets another, and both results are judged from the read value.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int DATA_W    = 32;
    localparam int NREG      = 6;
    localparam int INTR_IDX  = 5;
    localparam int VER_IDX   = 9;
    localparam int N_SRC     = 4;
    localparam int SRST_BIT  = 31;
    localparam int CGATE_BIT = 30;
    localparam int ENA_OFS   = 16;

    typedef enum logic [1:0] {OP_WRITE, OP_SET, OP_CLR, OP_TOG} alias_op_e;
    typedef enum logic [1:0] {ST_HELD, ST_GATED, ST_RUN} gate_state_e;

    function automatic int stat_pos(input int k);
        case (k)
            0:       return 1;
            1:       return 4;
            2:       return 5;
            default: return 6;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] intr_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int k = 0; k < N_SRC; k++) begin
            m[stat_pos(k)]           = 1'b1;
            m[stat_pos(k) + ENA_OFS] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] rst_val(input int i);
        logic [DATA_W-1:0] v;
        v = '0;
        if (i == 0) begin
            v[SRST_BIT]  = 1'b1;
            v[CGATE_BIT] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] impl_mask(input int i);
        return (i == INTR_IDX) ? intr_mask() : '1;
    endfunction

    function automatic logic [DATA_W-1:0] keep_mask(input int i);
        logic [DATA_W-1:0] v;
        v = '0;
        if (i == 0) v[SRST_BIT] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/scr_alias_reg.sv
module scr_alias_reg
    import scr_pkg::*;
#(
    parameter int              W        = 32,
    parameter logic [W-1:0]    RST_VAL  = '0,
    parameter logic [W-1:0]    IMPL     = '1,
    parameter logic [W-1:0]    KEEP     = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         wr_en,
    input  alias_op_e    op,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    logic [W-1:0] sw_val;
    logic [W-1:0] nxt;

    always_comb begin
        sw_val = q;
        if (wr_en) begin
            unique case (op)
                OP_WRITE: sw_val = wdata;
                OP_SET:   sw_val = q | wdata;
                OP_CLR:   sw_val = q & ~wdata;
                OP_TOG:   sw_val = q ^ wdata;
            endcase
        end
        nxt = (sw_val | hw_set) & IMPL;
        if (hold) nxt = (RST_VAL & ~KEEP) | (nxt & KEEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL & IMPL;
        else        q <= nxt;
    end

    AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_SET && !hold) |=> ((q & $past(wdata) & IMPL) == ($past(wdata) & IMPL))); // R2
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_CLR && !hold) |=> ((q & $past(wdata) & ~$past(hw_set)) == '0)); // R3
    AST_HOLD_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ((q & ~KEEP) == (RST_VAL & ~KEEP & IMPL))); // R7
endmodule

// File: rtl/scr_gate_fsm.sv
module scr_gate_fsm
    import scr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic cgate,
    output logic core_rst,
    output logic core_clk_en
);
    gate_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HELD;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HELD: begin
                if (!srst) nxt = cgate ? ST_GATED : ST_RUN;
            end
            ST_GATED: begin
                if (srst)        nxt = ST_HELD;
                else if (!cgate) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (srst)       nxt = ST_HELD;
                else if (cgate) nxt = ST_GATED;
            end
            default: nxt = ST_HELD;
        endcase
    end

    always_comb begin
        core_rst    = (state == ST_HELD);
        core_clk_en = (state == ST_RUN);
    end

    AST_SRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (state == ST_HELD)); // R8
    AST_RUN_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (srst || cgate) |=> (state != ST_RUN)); // R8
endmodule

// File: rtl/scr_irq_map.sv
module scr_irq_map
    import scr_pkg::*;
(
    input  logic [N_SRC-1:0]  evt,
    input  logic [DATA_W-1:0] intr_q,
    output logic [DATA_W-1:0] hw_set,
    output logic              irq
);
    logic [N_SRC-1:0] active;

    always_comb begin
        hw_set = '0;
        for (int k = 0; k < N_SRC; k++) hw_set[stat_pos(k)] = evt[k];
    end

    for (genvar k = 0; k < N_SRC; k++) begin : g_src
        assign active[k] = intr_q[stat_pos(k)] & intr_q[stat_pos(k) + ENA_OFS];
    end

    assign irq = |active;
endmodule

// File: rtl/scr_regbank.sv
module scr_regbank
    import scr_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [DATA_W-1:0] VERSION_VAL = 32'h0301_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [3:0]        evt_i,
    output logic              irq_o,
    output logic              core_rst_o,
    output logic              core_clk_en_o
);
    localparam int IDX_W = ADDR_W - 4;

    logic [IDX_W-1:0]              idx;
    alias_op_e                     op;
    logic                          aligned;
    logic                          hold;
    logic [NREG-1:0][DATA_W-1:0]   regs_q;
    logic [DATA_W-1:0]             intr_set;

    assign idx     = bus_addr[ADDR_W-1:4];
    assign op      = alias_op_e'(bus_addr[3:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign hold    = regs_q[0][SRST_BIT];

    scr_irq_map u_irq (
        .evt    (evt_i),
        .intr_q (regs_q[INTR_IDX]),
        .hw_set (intr_set),
        .irq    (irq_o)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        scr_alias_reg #(
            .W       (DATA_W),
            .RST_VAL (rst_val(i)),
            .IMPL    (impl_mask(i)),
            .KEEP    (keep_mask(i))
        ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .hold   (hold),
            .wr_en  (bus_wr && aligned && (idx == IDX_W'(i))),
            .op     (op),
            .wdata  (bus_wdata),
            .hw_set ((i == INTR_IDX) ? intr_set : '0),
            .q      (regs_q[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            for (int i = 0; i < NREG; i++)
                if (idx == IDX_W'(i)) bus_rdata = regs_q[i];
            if (idx == IDX_W'(VER_IDX) && bus_addr[3:2] == 2'b00)
                bus_rdata = VERSION_VAL;
        end
    end

    scr_gate_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .srst        (regs_q[0][SRST_BIT]),
        .cgate       (regs_q[0][CGATE_BIT]),
        .core_rst    (core_rst_o),
        .core_clk_en (core_clk_en_o)
    );

    AST_RX_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[1] && !hold) |=> regs_q[INTR_IDX][4]); // R6
    AST_CTS_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i[0] && !hold) |=> regs_q[INTR_IDX][1]); // R6
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((regs_q[INTR_IDX][22:16] & regs_q[INTR_IDX][6:0]) != '0)); // R5
endmodule

// File: tb/scr_regbank_tb.sv
module scr_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  evt_i = '0;
    logic        irq_o, core_rst_o, core_clk_en_o;
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    localparam logic [31:0] VER = 32'h0301_0000;

    always #2.5 clk = ~clk;

    scr_regbank #(.ADDR_W(8), .VERSION_VAL(VER)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
        .irq_o(irq_o), .core_rst_o(core_rst_o), .core_clk_en_o(core_clk_en_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic pulse_evt(input logic [3:0] m);
        @(negedge clk);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset_state;
        rd_chk("R10 ctrl0 reset", 8'h00, 32'hC000_0000);
        rd_chk("R10 ctrl1 reset", 8'h10, 32'h0);
        rd_chk("R10 intr reset", 8'h50, 32'h0);
        chk("R10 irq reset", {31'b0, irq_o}, 32'd0);
        chk("R8 held rst", {31'b0, core_rst_o}, 32'd1);
        chk("R8 held clk_en", {31'b0, core_clk_en_o}, 32'd0);
    endtask

    task automatic t_release;
        wr(8'h08, 32'h8000_0000);
        rd_chk("R7 srst clear visible", 8'h00, 32'h4000_0000);
        chk("R8 gated rst", {31'b0, core_rst_o}, 32'd0);
        chk("R8 gated clk_en", {31'b0, core_clk_en_o}, 32'd0);
        wr(8'h08, 32'h4000_0000);
        rd_chk("R3 cgate cleared", 8'h00, 32'h0);
        chk("R8 run clk_en", {31'b0, core_clk_en_o}, 32'd1);
    endtask

    task automatic t_aliases;
        wr(8'h10, 32'h1234_5678);
        rd_chk("R1 base", 8'h10, 32'h1234_5678);
        rd_chk("R1 set alias read", 8'h14, 32'h1234_5678);
        rd_chk("R1 clr alias read", 8'h18, 32'h1234_5678);
        rd_chk("R1 tog alias read", 8'h1C, 32'h1234_5678);
        wr(8'h14, 32'h0000_FF00);
        rd_chk("R2 set", 8'h10, 32'h1234_FF78);
        wr(8'h18, 32'h1200_0078);
        rd_chk("R3 clear", 8'h10, 32'h0034_FF00);
        wr(8'h1C, 32'hFFFF_0000);
        rd_chk("R4 toggle", 8'h10, 32'hFFCB_FF00);
        wr(8'h30, 32'hA5A5_A5A5);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd_chk("R4 toggle line", 8'h30, 32'h5A5A_5A5A);
        wr(8'h44, 32'h0000_0101);
        rd_chk("R2 set line2", 8'h40, 32'h0000_0101);
        rd_chk("R1 ctrl2 untouched", 8'h20, 32'h0);
    endtask

    task automatic t_intr;
        wr(8'h50, 32'hFFFF_FFFF);
        rd_chk("R5 implemented bits", 8'h50, 32'h0072_0072);
        chk("R5 irq on", {31'b0, irq_o}, 32'd1);
        wr(8'h58, 32'h0000_0072);
        rd_chk("R5 ack status", 8'h50, 32'h0072_0000);
        chk("R5 irq off", {31'b0, irq_o}, 32'd0);
        wr(8'h58, 32'h0072_0000);
        pulse_evt(4'b0010);
        rd_chk("R6 rx evt sets bit4", 8'h50, 32'h0000_0010);
        chk("R5 masked irq", {31'b0, irq_o}, 32'd0);
        wr(8'h54, 32'h0010_0000);
        chk("R5 enabled irq", {31'b0, irq_o}, 32'd1);
        pulse_evt(4'b1001);
        rd_chk("R6 cts+rto evt", 8'h50, 32'h0010_0052);
        wr(8'h58, 32'h0000_0042);
    endtask

    task automatic t_collision;
        @(negedge clk);
        bus_addr = 8'h58; bus_wr = 1'b1; bus_wdata = 32'h0000_0010; evt_i = 4'b0010;
        @(negedge clk);
        bus_wr = 1'b0; evt_i = '0;
        rd_chk("R6 set wins same bit", 8'h50, 32'h0010_0010);
        @(negedge clk);
        bus_addr = 8'h58; bus_wr = 1'b1; bus_wdata = 32'h0000_0010; evt_i = 4'b0001;
        @(negedge clk);
        bus_wr = 1'b0; evt_i = '0;
        rd_chk("R6 clear other bit", 8'h50, 32'h0010_0002);
        chk("R5 irq unpaired", {31'b0, irq_o}, 32'd0);
    endtask

    task automatic t_unmapped;
        rd_chk("R9 version", 8'h90, VER);
        wr(8'h60, 32'hFFFF_FFFF);
        wr(8'hA0, 32'hFFFF_FFFF);
        wr(8'h11, 32'h0);
        rd_chk("R9 data reads 0", 8'h60, 32'h0);
        rd_chk("R9 stat reads 0", 8'h70, 32'h0);
        rd_chk("R9 autobaud reads 0", 8'hA0, 32'h0);
        rd_chk("R9 version alias 0", 8'h94, 32'h0);
        rd_chk("R9 misaligned 0", 8'h11, 32'h0);
        rd_chk("R9 ctrl1 untouched", 8'h10, 32'hFFCB_FF00);
    endtask

    task automatic t_soft_reset;
        wr(8'h04, 32'h8000_0000);
        rd_chk("R7 ctrl0 forced", 8'h00, 32'hC000_0000);
        rd_chk("R7 ctrl1 forced", 8'h10, 32'h0);
        rd_chk("R7 intr forced", 8'h50, 32'h0);
        chk("R8 back to held", {31'b0, core_rst_o}, 32'd1);
        pulse_evt(4'b1111);
        rd_chk("R7 evt ignored in hold", 8'h50, 32'h0);
        wr(8'h10, 32'h0000_0055);
        rd_chk("R7 write ignored in hold", 8'h10, 32'h0);
        wr(8'h08, 32'h8000_0000);
        wr(8'h08, 32'h4000_0000);
        rd_chk("R7 released", 8'h00, 32'h0);
    endtask

    task automatic t_hw_reset;
        wr(8'h20, 32'hDEAD_BEEF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R10 ctrl2 reset", 8'h20, 32'h0);
        rd_chk("R10 ctrl0 reset again", 8'h00, 32'hC000_0000);
        chk("R10 fsm held", {31'b0, core_rst_o}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_release();
        t_aliases();
        t_intr();
        t_collision();
        t_unmapped();
        t_soft_reset();
        t_hw_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule